// File: doc/BRIEF.md
# Packed-Field Word Editor

This block edits a single memory word that holds a fixed number of equal-width packed fields, a spare body bit and a flag bit at the top. It can insert a new field at a chosen slot, which moves every later field one slot up, or delete the field in a slot, which moves every later field one slot down. Each edited word gets a self-delimiting tail: one 0 bit directly after the last valid field, then 1 bits up to the top of the body. From that tail the occupancy of the word can always be recovered in place.

If an insert hits a word that is already full, and the caller says a freshly emptied neighbour word is available, the field pushed off the top comes out as a ready-formatted neighbour word. That word holds the spilled field in slot 0 and is followed by the same tail pattern. An occupancy decoder reports how many valid fields the result word holds. Each request takes one clock cycle, and all outputs are registered.

The block is meant to sit beside a memory that can shift whole regions by one word. Software or a controller reads a word, sends an edit through this unit, writes the result back and, on a spill, writes the spill word into the gap the shift opened.

Top module: `packed_field_editor`

## Requirements
- R1: A word is WW = NF*FW+2 bits wide. Slot i occupies bits [i*FW +: FW], so slot 0 is at the least significant end. Bit NF*FW is the spare body bit and bit WW-1 is the flag: 0 means unmodified, 1 means modified. An unmodified word counts as holding NF fields. Every successful insert or delete sets the flag to 1.
- R2: For a modified word, the count is p/FW, where p is the highest body bit (bits NF*FW down to 0) that is 0. If the body has no 0 bit, the count is 0. The count of the result word is reported on out_count.
- R3: Insert (in_op = 2'b01) with count k < NF and slot s <= k gives a word with these contents: the old fields below s are unchanged, the new value is in slot s, and old fields s..k-1 are in slots s+1..k. The count becomes k+1, and the word carries the 0-then-1s tail above the last field. No spill is reported.
- R4: Insert into a full word (k = NF) with s < NF and in_spill_ok = 1 builds the same layout and drops old slot NF-1 from the word, so the count stays NF. out_spill_valid rises. out_spill_word holds that old field in slot 0 with a count of 1 and the flag set.
- R5: Insert into a full word with in_spill_ok = 0 raises out_err and returns the input word unchanged.
- R6: Insert with s >= NF or s > k raises out_err and returns the input word unchanged.
- R7: Delete (in_op = 2'b10) with s < k gives a word where old fields s+1..k-1 move to slots s..k-2. The count becomes k-1, the tail starts right after the last field, and the flag is 1.
- R8: Delete with s >= k raises out_err and returns the input word unchanged.
- R9: Ops 2'b00 and 2'b11 pass the word through unchanged, with no error and no spill.
- R10: The results of a request sampled with in_valid at a rising edge appear after that edge, with out_valid = 1. In a cycle that follows an edge without in_valid, out_valid, out_err and out_spill_valid are 0.
- R11: Reset gives out_valid = 0, out_err = 0, out_spill_valid = 0, out_word = 0 and out_count = NF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 00 pass, 01 insert, 10 delete, 11 pass |
| in_word | input | NF*FW+2 | Word to edit |
| in_slot | input | clog2(NF+1) | Target slot |
| in_value | input | FW | Field to insert |
| in_spill_ok | input | 1 | Neighbour word is free to take a spill |
| out_valid | output | 1 | Result strobe |
| out_word | output | NF*FW+2 | Edited word, or the input word on error or pass |
| out_err | output | 1 | Request rejected |
| out_spill_valid | output | 1 | Spill word produced |
| out_spill_word | output | NF*FW+2 | Formatted neighbour word |
| out_count | output | clog2(NF+1) | Valid fields in out_word |

## Verification
The assertions assume that in_op, in_word and in_slot are stable and known whenever in_valid is sampled. They compare each output with the request of the previous cycle. They also assume that a modified input word obeys the tail format, except where a malformed word is presented on purpose. The stimulus builds every input word from a field list and a count with the bench's own formatter, and adds just one deliberate all-ones modified body. Inputs change only on falling edges, and each request holds for exactly one cycle.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   typedef enum logic [1:0] {
      SFE_PASS = 2'b00,
      SFE_INS  = 2'b01,
      SFE_DEL  = 2'b10,
      SFE_RSV  = 2'b11
   } sfe_op_e;
endpackage

// File: rtl/sfe_occupancy.sv
// Recovers the valid-field count of one word from its flag and tail (R1, R2).
module sfe_occupancy #(
   parameter int FW = 8,
   parameter int NF = 4
) (
   input  logic [NF*FW+1:0]         word,
   output logic [$clog2(NF+1)-1:0]  count
);
   localparam int BW = NF*FW + 1;
   localparam int WW = BW + 1;
   localparam int CW = $clog2(NF+1);

   always_comb begin
      logic found;
      found = 1'b0;
      count = CW'(NF);
      if (word[WW-1]) begin
         count = '0;
         for (int b = BW-1; b >= 0; b--) begin
            if (!found && !word[b]) begin
               found = 1'b1;
               count = CW'(b / FW);
            end
         end
      end
   end
endmodule

// File: rtl/sfe_pack.sv
// Formats a field list and a count into a modified word with its tail.
module sfe_pack #(
   parameter int FW = 8,
   parameter int NF = 4
) (
   input  logic [NF*FW-1:0]         fields,
   input  logic [$clog2(NF+1)-1:0]  n,
   output logic [NF*FW+1:0]         word
);
   localparam int CW = $clog2(NF+1);
   localparam logic [FW-1:0] TAIL_HEAD = ~FW'(1);

   for (genvar g = 0; g < NF; g++) begin : g_slot
      assign word[g*FW +: FW] = (CW'(g) <  n) ? fields[g*FW +: FW] :
                                (CW'(g) == n) ? TAIL_HEAD : '1;
   end
   assign word[NF*FW]   = (n != CW'(NF));
   assign word[NF*FW+1] = 1'b1;
endmodule

// File: rtl/sfe_edit_core.sv
// Combinational insert/delete rearrangement and legality checks.
module sfe_edit_core
   import sfe_pkg::*;
#(
   parameter int FW = 8,
   parameter int NF = 4
) (
   input  logic [1:0]               op,
   input  logic [NF*FW-1:0]         old_f,
   input  logic [$clog2(NF+1)-1:0]  count,
   input  logic [$clog2(NF+1)-1:0]  slot,
   input  logic [FW-1:0]            value,
   input  logic                     spill_ok,
   output logic [NF*FW-1:0]         new_f,
   output logic [$clog2(NF+1)-1:0]  new_n,
   output logic [NF*FW-1:0]         spill_f,
   output logic                     edit,
   output logic                     err,
   output logic                     spill
);
   localparam int CW = $clog2(NF+1);
   localparam logic [CW-1:0] FULL = CW'(NF);

   logic [NF*FW-1:0] ins_f, del_f;
   logic is_ins, is_del, ins_bad, del_bad;

   for (genvar j = 0; j < NF; j++) begin : g_lane
      if (j == 0) begin : g_first
         assign ins_f[0 +: FW] = (slot == '0) ? value : old_f[0 +: FW];
      end else begin : g_rest
         assign ins_f[j*FW +: FW] = (CW'(j) <  slot) ? old_f[j*FW +: FW] :
                                    (CW'(j) == slot) ? value : old_f[(j-1)*FW +: FW];
      end
      if (j == NF-1) begin : g_last
         assign del_f[j*FW +: FW] = (CW'(j) < slot) ? old_f[j*FW +: FW] : '1;
      end else begin : g_mid
         assign del_f[j*FW +: FW] = (CW'(j) < slot) ? old_f[j*FW +: FW] : old_f[(j+1)*FW +: FW];
      end
   end

   assign is_ins  = (op == SFE_INS);
   assign is_del  = (op == SFE_DEL);
   assign ins_bad = (slot >= FULL) || (slot > count) || ((count == FULL) && !spill_ok);
   assign del_bad = (slot >= count);

   assign err   = (is_ins && ins_bad) || (is_del && del_bad);
   assign edit  = (is_ins && !ins_bad) || (is_del && !del_bad);
   assign spill = is_ins && !ins_bad && (count == FULL);
   assign new_f = is_ins ? ins_f : del_f;
   assign new_n = is_ins ? ((count == FULL) ? FULL : count + CW'(1)) : count - CW'(1);
   assign spill_f = {{((NF-1)*FW){1'b1}}, old_f[(NF-1)*FW +: FW]};
endmodule

// File: rtl/packed_field_editor.sv
module packed_field_editor #(
   parameter int FW = 8,
   parameter int NF = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [1:0]               in_op,
   input  logic [NF*FW+1:0]         in_word,
   input  logic [$clog2(NF+1)-1:0]  in_slot,
   input  logic [FW-1:0]            in_value,
   input  logic                     in_spill_ok,
   output logic                     out_valid,
   output logic [NF*FW+1:0]         out_word,
   output logic                     out_err,
   output logic                     out_spill_valid,
   output logic [NF*FW+1:0]         out_spill_word,
   output logic [$clog2(NF+1)-1:0]  out_count
);
   localparam int WW = NF*FW + 2;
   localparam int CW = $clog2(NF+1);

   if (FW < 2) begin : g_bad_fw
      $error("packed_field_editor: FW must be at least 2");
   end
   if (NF < 2) begin : g_bad_nf
      $error("packed_field_editor: NF must be at least 2");
   end

   logic [CW-1:0]    in_cnt, nx_cnt, new_n;
   logic [NF*FW-1:0] new_f, spill_f;
   logic             edit_c, err_c, spill_c;
   logic [WW-1:0]    pk_word, pk_spill, nx_word;

   sfe_occupancy #(.FW(FW), .NF(NF)) u_in_occ (.word(in_word), .count(in_cnt));

   sfe_edit_core #(.FW(FW), .NF(NF)) u_core (
      .op(in_op), .old_f(in_word[NF*FW-1:0]), .count(in_cnt), .slot(in_slot),
      .value(in_value), .spill_ok(in_spill_ok), .new_f(new_f), .new_n(new_n),
      .spill_f(spill_f), .edit(edit_c), .err(err_c), .spill(spill_c));

   sfe_pack #(.FW(FW), .NF(NF)) u_pack_main  (.fields(new_f),   .n(new_n),  .word(pk_word));
   sfe_pack #(.FW(FW), .NF(NF)) u_pack_spill (.fields(spill_f), .n(CW'(1)), .word(pk_spill));

   assign nx_word = edit_c ? pk_word : in_word;

   sfe_occupancy #(.FW(FW), .NF(NF)) u_out_occ (.word(nx_word), .count(nx_cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid       <= 1'b0;
         out_err         <= 1'b0;
         out_spill_valid <= 1'b0;
         out_word        <= '0;
         out_spill_word  <= '0;
         out_count       <= CW'(NF);
      end else begin
         out_valid       <= in_valid;
         out_err         <= in_valid && err_c;
         out_spill_valid <= in_valid && spill_c;
         if (in_valid) begin
            out_word  <= nx_word;
            out_count <= nx_cnt;
         end
         if (in_valid && spill_c) out_spill_word <= pk_spill;
      end
   end
endmodule

// File: rtl/sfe_chk.sv
module sfe_chk
   import sfe_pkg::*;
#(
   parameter int FW = 8,
   parameter int NF = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic [1:0]               in_op,
   input logic [NF*FW+1:0]         in_word,
   input logic                     out_valid,
   input logic [NF*FW+1:0]         out_word,
   input logic                     out_err,
   input logic                     out_spill_valid,
   input logic [NF*FW+1:0]         out_spill_word,
   input logic [$clog2(NF+1)-1:0]  out_count
);
   localparam int WW = NF*FW + 2;

   // R10
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_err && !out_spill_valid));

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_word == $past(in_word)));

   // R4
   spill_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_spill_valid |-> (!out_err && out_count == ($clog2(NF+1))'(NF)
                           && out_spill_word[WW-1] && $past(in_op) == SFE_INS));

   // R9
   pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ($past(in_op) == SFE_PASS || $past(in_op) == SFE_RSV))
      |-> (out_word == $past(in_word) && !out_err && !out_spill_valid));

   // R1
   edit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err && ($past(in_op) == SFE_INS || $past(in_op) == SFE_DEL))
      |-> out_word[WW-1]);

   // R7
   del_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err && $past(in_op) == SFE_DEL)
      |-> (out_count < ($clog2(NF+1))'(NF)));
endmodule

bind packed_field_editor sfe_chk #(.FW(FW), .NF(NF)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_word(in_word),
   .out_valid(out_valid), .out_word(out_word), .out_err(out_err),
   .out_spill_valid(out_spill_valid), .out_spill_word(out_spill_word),
   .out_count(out_count));

// File: tb/packed_field_editor_tb.sv
module packed_field_editor_tb;
   localparam int FW = 3;
   localparam int NF = 4;
   localparam int DW = NF*FW;
   localparam int WW = DW + 2;
   localparam int CW = $clog2(NF+1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_spill_ok = 1'b0;
   logic [1:0] in_op = '0;
   logic [WW-1:0] in_word = '0;
   logic [CW-1:0] in_slot = '0;
   logic [FW-1:0] in_value = '0;
   logic out_valid, out_err, out_spill_valid;
   logic [WW-1:0] out_word, out_spill_word;
   logic [CW-1:0] out_count;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   packed_field_editor #(.FW(FW), .NF(NF)) u_dut (.*);

   function automatic logic [WW-1:0] fmt(input logic [DW-1:0] f, input int n);
      logic [WW-1:0] w;
      w = '1;
      for (int b = 0; b < n*FW; b++) w[b] = f[b];
      w[n*FW] = 1'b0;
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                      input logic [WW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] op, input logic [WW-1:0] w, input int slot,
                      input logic [FW-1:0] v, input bit sok, input logic [WW-1:0] ew,
                      input bit ee, input bit es, input logic [WW-1:0] esw, input int ecnt,
                      input string req);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_word = w; in_slot = CW'(slot);
      in_value = v; in_spill_ok = sok;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid === 1'b1, {req, " R10 valid"}, WW'(out_valid), 1);
      chk(out_word === ew, {req, " word"}, out_word, ew);
      chk(out_err === ee, {req, " err"}, WW'(out_err), WW'(ee));
      chk(out_spill_valid === es, {req, " spill flag"}, WW'(out_spill_valid), WW'(es));
      if (es) chk(out_spill_word === esw, {req, " R4 spill word"}, out_spill_word, esw);
      chk(int'(out_count) == ecnt, {req, " R2 count"}, WW'(out_count), WW'(ecnt));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0 && out_err === 1'b0 && out_spill_valid === 1'b0,
          "R11 reset flags", {out_valid, out_err, out_spill_valid}, '0);
      chk(out_word === '0 && int'(out_count) == NF, "R11 reset word/count",
          out_word, '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int seed = 0; seed < 2; seed++) begin
         logic [DW-1:0] base;
         logic [FW-1:0] v;
         for (int i = 0; i < NF; i++) base[i*FW +: FW] = FW'(seed*5 + i*3 + 1);
         v = FW'(seed + 6);
         for (int k = 0; k <= NF + 1; k++) begin
            bit unmod;
            int kk;
            logic [WW-1:0] w;
            unmod = (k == NF + 1);
            kk = unmod ? NF : k;
            w = unmod ? {2'b00, base} : fmt(base, kk);
            run(2'b00, w, 0, v, 0, w, 0, 0, '0, kk, "R9 pass");
            run(2'b11, w, 1, v, 1, w, 0, 0, '0, kk, "R9 reserved");
            for (int s = 0; s <= NF; s++) begin
               for (int sok = 0; sok < 2; sok++) begin
                  logic [DW-1:0] nf;
                  logic [WW-1:0] sw;
                  bit bad;
                  bad = (s >= NF) || (s > kk) || (kk == NF && sok == 0);
                  for (int j = 0; j < NF; j++)
                     nf[j*FW +: FW] = (j < s) ? base[j*FW +: FW] :
                                      (j == s) ? v : base[(j-1)*FW +: FW];
                  sw = fmt({{(DW-FW){1'b1}}, base[(NF-1)*FW +: FW]}, 1);
                  if (bad)
                     run(2'b01, w, s, v, sok[0], w, 1, 0, '0, kk,
                         (kk == NF && s < NF) ? "R5 ins full" : "R6 ins slot");
                  else if (kk == NF)
                     run(2'b01, w, s, v, sok[0], fmt(nf, NF), 0, 1, sw, NF, "R4 ins spill");
                  else
                     run(2'b01, w, s, v, sok[0], fmt(nf, kk+1), 0, 0, '0, kk+1, "R3 ins");
               end
               begin
                  logic [DW-1:0] df;
                  df = '1;
                  for (int j = 0; j < NF; j++)
                     df[j*FW +: FW] = (j < s) ? base[j*FW +: FW] :
                                      (j + 1 < NF) ? base[(j+1)*FW +: FW] : '1;
                  if (s >= kk)
                     run(2'b10, w, s, v, 0, w, 1, 0, '0, kk, "R8 del slot");
                  else
                     run(2'b10, w, s, v, 0, fmt(df, kk-1), 0, 0, '0, kk-1, "R7 del");
               end
            end
         end
      end

      // Malformed modified word: all-ones body counts as empty (R2).
      run(2'b00, '1, 0, 3'd5, 0, '1, 0, 0, '0, 0, "R2 no zero");
      run(2'b10, '1, 0, 3'd5, 0, '1, 1, 0, '0, 0, "R8 del empty");
      run(2'b01, '1, 0, 3'd5, 0, fmt({{(DW-FW){1'b1}}, 3'd5}, 1), 0, 0, '0, 1,
          "R3 ins empty");
      // Insert into an unmodified word flips the flag (R1).
      run(2'b01, {2'b00, 12'h000}, 0, 3'd7, 1, fmt(12'h007, NF), 0, 1,
          fmt({{(DW-FW){1'b1}}, 3'd0}, 1), NF, "R1 flag set");

      @(negedge clk);
      chk(out_valid === 1'b0 && out_err === 1'b0 && out_spill_valid === 1'b0,
          "R10 idle", {out_valid, out_err, out_spill_valid}, '0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule